// File: doc/BRIEF.md
# Clipped Cursor Image Loader

This block takes a small ARGB cursor image placed at a signed screen position and works out which part of it is visible. The cursor may hang over any of the four screen edges, and the block clips it on all of them. It then streams only the visible pixels from a source image into a dedicated cursor SRAM. The SRAM uses a split address map with two banks. The block also produces the packed screen position and visible size words that the display pipe uses to place the overlay.

A request is one `start` pulse. It carries the cursor width and height, the signed x and y, the active display size, an interlace flag and a `reload` flag. A request that keeps the visible size and does not ask for a reload only updates the position. A request that changes the visible size, asks for a reload, or finds the SRAM contents lost rewrites the image. After a loss of SRAM contents the transparency table is filled first. The new position and size take effect only on the next `frame_done` pulse. This keeps a frame from being drawn with half-updated values.

Source pixels are fetched through a simple read port. `src_data` must hold the pixel for a request during the cycle that follows the cycle in which `src_rd_en` was high.

Top module: `cursor_overlay_loader`

## Requirements
- R1: A request whose width or height exceeds 64, or whose width and height both exceed 32, is ignored. `busy` stays low, nothing is written and the cursor outputs keep their values. Sizes of 64x32 and 32x64 are accepted.
- R2: Negative x or y clipping:
  - The screen coordinate on that axis becomes 0.
  - The image is entered |x| columns (or |y| rows) in.
  - The visible extent is the size minus that skip, floored at 0.
- R3: When position plus size passes the active width (height), the visible extent is the active size minus the position, floored at 0, and the screen coordinate is the position.
- R4: With `interlace` high:
  - The source line stride is twice the width.
  - The visible height and the screen y are both halved, rounding down, after clipping.
- R5: If the visible width or height is 0, nothing is written, `cur_en` drops to 0 and no update is left pending. A later `frame_done` does not re-enable the cursor.
- R6: Each stored pixel has byte 0 (bits 7:0) and byte 2 (bits 23:16) of the source pixel exchanged. Bytes 1 and 3 are kept in place.
- R7: Image SRAM addresses:
  - They start at 0x0C00 and advance by one per pixel.
  - When the low 8 bits become zero, 0x0F00 is added.
  - When the result ANDed with 0x30FF is zero, the address restarts at 0x0D00.
  - So pixel 256 lands at 0x1C00 and pixel 1024 at 0x0D00.
- R8: After reset, or after a `sram_sleep` pulse, the next accepted request with a visible cursor first writes 0x55555555 to addresses 0x0E00 to 0x0EFF in ascending order. It then reloads the image even if neither `reload` nor a size change asks for it.
- R9: Packing and commit of the output words:
  - `cur_pos` is {screen y, screen x}, 16 bits each.
  - `cur_size` is {visible height, visible width}, 16 bits each.
  - Both, together with `cur_en`=1, are updated only on the clock edge that samples `frame_done` high while an update is pending.
- R10: A visible size different from the last one loaded forces an image load and clears `cur_en` at once. A same-size request without `reload` writes nothing and leaves the displayed cursor enabled until the commit.
- R11: Visible pixels are written in row-major order. Pixel (r, c) comes from source word yoff*stride + xoff + r*stride + c, where xoff and yoff are the skips from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken while idle |
| reload | input | 1 | Request asks for the image to be rewritten |
| cur_w | input | 7 | Cursor image width |
| cur_h | input | 7 | Cursor image height |
| cur_x | input | 16 | Signed screen x of the image's left column |
| cur_y | input | 16 | Signed screen y of the image's top row |
| act_w | input | 16 | Active display width |
| act_h | input | 16 | Active display height |
| interlace | input | 1 | Interlaced output mode |
| sram_sleep | input | 1 | Pulse: cursor SRAM contents were lost |
| frame_done | input | 1 | Frame boundary pulse that commits pending values |
| src_rd_en | output | 1 | Source pixel read request |
| src_addr | output | 13 | Source pixel word index |
| src_data | input | 32 | Source pixel, one cycle after the request |
| sram_we | output | 1 | Cursor SRAM write strobe |
| sram_addr | output | 16 | Cursor SRAM write address |
| sram_wdata | output | 32 | Cursor SRAM write data |
| busy | output | 1 | Request in progress |
| cur_en | output | 1 | Cursor overlay enabled |
| cur_pos | output | 32 | Committed {y, x} screen position |
| cur_size | output | 32 | Committed {height, width} visible size |

## Verification
The bench places cursors half off the left and top edges and past the right and bottom edges. A sign or floor mistake there shows up as a wrong visible size in `cur_size` and a shifted source window in the written pixel stream.

A 64x32 load crosses every 256-word block and the bank switch. An address sequencer that skips the 0x0F00 jump or the restart at 0x0D00 writes pixels 256 and 1024 to the wrong places.

The bench also covers:
- an interlaced load, where a missing stride doubling fetches the wrong source rows;
- a fully clipped cursor, which must stay disabled through the next frame;
- an oversized request, which must leave every output untouched;
- a lost-SRAM event, after which a design that forgot the transparency fill or the forced reload writes too few words.

// File: rtl/curs_pkg.sv
package curs_pkg;

  localparam int unsigned CUR_AW = 16;
  localparam int unsigned PIX_DW = 32;
  localparam logic [CUR_AW-1:0] BLOCK_SKIP = 16'h0F00;
  localparam logic [CUR_AW-1:0] BANK_MASK  = 16'h30FF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CALC,
    S_TRAN,
    S_LOAD,
    S_FIN
  } cur_st_e;

  // exchange the first and third bytes of a pixel
  function automatic logic [PIX_DW-1:0] swap_rb(input logic [PIX_DW-1:0] p);
    return {p[31:24], p[7:0], p[15:8], p[23:16]};
  endfunction

  // one step of the split cursor SRAM address walk
  function automatic logic [CUR_AW-1:0] step_addr(input logic [CUR_AW-1:0] a,
                                                  input logic [CUR_AW-1:0] bank2);
    logic [CUR_AW-1:0] n;
    n = a + 1'b1;
    if (n[7:0] == 8'h00) n = n + BLOCK_SKIP;
    if ((n & BANK_MASK) == '0) n = bank2;
    return n;
  endfunction

endpackage

// File: rtl/cursor_axis_clip.sv
module cursor_axis_clip #(
  parameter int COORD_W = 16,
  parameter int SZ_W    = 7
) (
  input  logic signed [COORD_W-1:0] pos,
  input  logic        [SZ_W-1:0]    size,
  input  logic        [COORD_W-1:0] act,
  output logic        [COORD_W-1:0] scr,
  output logic        [SZ_W-1:0]    off,
  output logic        [SZ_W-1:0]    vis
);
  localparam int XW = COORD_W + 2;

  logic signed [XW-1:0] pos_x, act_x, size_x, end_x, neg_x, room;

  always_comb begin
    pos_x  = XW'(pos);
    act_x  = $signed({2'b00, act});
    size_x = $signed({{(XW-SZ_W){1'b0}}, size});
    end_x  = pos_x + size_x;
    neg_x  = -pos_x;
    room   = act_x - pos_x;
    scr    = COORD_W'(pos_x);
    off    = '0;
    vis    = size;
    if (pos_x < 0) begin
      scr = '0;
      if (neg_x >= size_x) begin
        vis = '0;
      end else begin
        off = SZ_W'(neg_x);
        vis = size - SZ_W'(neg_x);
      end
    end else if (end_x > act_x) begin
      vis = (room > 0) ? SZ_W'(room) : '0;
    end
  end

endmodule

// File: rtl/cursor_geom.sv
module cursor_geom #(
  parameter int COORD_W = 16,
  parameter int SZ_W    = 7,
  parameter int SRC_AW  = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic        [SZ_W-1:0]    w,
  input  logic        [SZ_W-1:0]    h,
  input  logic signed [COORD_W-1:0] x,
  input  logic signed [COORD_W-1:0] y,
  input  logic        [COORD_W-1:0] hact,
  input  logic        [COORD_W-1:0] vact,
  input  logic                      ilace,
  output logic        [COORD_W-1:0] scr_x,
  output logic        [COORD_W-1:0] scr_y,
  output logic        [SZ_W-1:0]    vis_w,
  output logic        [SZ_W-1:0]    vis_h,
  output logic        [SRC_AW-1:0]  src_start,
  output logic        [SZ_W:0]      stride
);
  localparam int AXES = 2;

  logic signed [COORD_W-1:0] pos_a  [AXES];
  logic        [SZ_W-1:0]    size_a [AXES];
  logic        [COORD_W-1:0] act_a  [AXES];
  logic        [COORD_W-1:0] scr_a  [AXES];
  logic        [SZ_W-1:0]    off_a  [AXES];
  logic        [SZ_W-1:0]    vis_a  [AXES];

  assign pos_a[0]  = x;
  assign pos_a[1]  = y;
  assign size_a[0] = w;
  assign size_a[1] = h;
  assign act_a[0]  = hact;
  assign act_a[1]  = vact;

  generate
    for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
      cursor_axis_clip #(.COORD_W(COORD_W), .SZ_W(SZ_W)) u_clip (
        .pos (pos_a[ax]),
        .size(size_a[ax]),
        .act (act_a[ax]),
        .scr (scr_a[ax]),
        .off (off_a[ax]),
        .vis (vis_a[ax])
      );
    end
  endgenerate

  logic [SZ_W:0]     stride_n;
  logic [SRC_AW-1:0] start_n;

  always_comb begin
    stride_n = ilace ? {w, 1'b0} : {1'b0, w};
    start_n  = SRC_AW'(off_a[1]) * SRC_AW'(stride_n) + SRC_AW'(off_a[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scr_x     <= '0;
      scr_y     <= '0;
      vis_w     <= '0;
      vis_h     <= '0;
      src_start <= '0;
      stride    <= '0;
    end else if (load) begin
      scr_x     <= scr_a[0];
      vis_w     <= vis_a[0];
      scr_y     <= ilace ? (scr_a[1] >> 1) : scr_a[1];
      vis_h     <= ilace ? (vis_a[1] >> 1) : vis_a[1];
      src_start <= start_n;
      stride    <= stride_n;
    end
  end

endmodule

// File: rtl/cursor_src_walker.sv
module cursor_src_walker #(
  parameter int SZ_W   = 7,
  parameter int SRC_AW = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [SRC_AW-1:0] base,
  input  logic [SZ_W:0]     stride,
  input  logic [SZ_W-1:0]   vis_w,
  input  logic [SZ_W-1:0]   vis_h,
  output logic              src_rd_en,
  output logic [SRC_AW-1:0] src_addr
);
  logic              active;
  logic [SZ_W-1:0]   row, col;
  logic [SRC_AW-1:0] row_base;
  logic              row_end, last_row;

  assign row_end  = (col == SZ_W'(vis_w - 1'b1));
  assign last_row = (row == SZ_W'(vis_h - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      row       <= '0;
      col       <= '0;
      row_base  <= '0;
      src_rd_en <= 1'b0;
      src_addr  <= '0;
    end else begin
      src_rd_en <= 1'b0;
      if (go) begin
        active   <= 1'b1;
        row      <= '0;
        col      <= '0;
        row_base <= base;
      end else if (active) begin
        src_rd_en <= 1'b1;
        src_addr  <= row_base + SRC_AW'(col);
        if (row_end) begin
          col      <= '0;
          row      <= row + 1'b1;
          row_base <= row_base + SRC_AW'(stride);
          if (last_row) active <= 1'b0;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cursor_sram_seq.sv
module cursor_sram_seq
  import curs_pkg::*;
#(
  parameter logic [CUR_AW-1:0] BANK1 = 16'h0C00,
  parameter logic [CUR_AW-1:0] BANK2 = 16'h0D00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  output logic [CUR_AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst || restart) addr <= BANK1;
    else if (step)      addr <= step_addr(addr, BANK2);
  end
endmodule

// File: rtl/cursor_overlay_loader.sv
module cursor_overlay_loader
  import curs_pkg::*;
#(
  parameter int                MAX_DIM    = 64,
  parameter int                MAX_BOTH   = 32,
  parameter int                COORD_W    = 16,
  parameter logic [CUR_AW-1:0] BANK1_BASE = 16'h0C00,
  parameter logic [CUR_AW-1:0] BANK2_BASE = 16'h0D00,
  parameter logic [CUR_AW-1:0] TRAN_BASE  = 16'h0E00,
  parameter int                TRAN_WORDS = 256,
  parameter logic [PIX_DW-1:0] TRAN_FILL  = 32'h5555_5555,
  localparam int SZ_W   = $clog2(MAX_DIM + 1),
  localparam int SRC_AW = $clog2(2 * MAX_DIM * MAX_BOTH) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      reload,
  input  logic        [SZ_W-1:0]    cur_w,
  input  logic        [SZ_W-1:0]    cur_h,
  input  logic signed [COORD_W-1:0] cur_x,
  input  logic signed [COORD_W-1:0] cur_y,
  input  logic        [COORD_W-1:0] act_w,
  input  logic        [COORD_W-1:0] act_h,
  input  logic                      interlace,
  input  logic                      sram_sleep,
  input  logic                      frame_done,
  output logic                      src_rd_en,
  output logic        [SRC_AW-1:0]  src_addr,
  input  logic        [PIX_DW-1:0]  src_data,
  output logic                      sram_we,
  output logic        [CUR_AW-1:0]  sram_addr,
  output logic        [PIX_DW-1:0]  sram_wdata,
  output logic                      busy,
  output logic                      cur_en,
  output logic        [2*COORD_W-1:0] cur_pos,
  output logic        [2*COORD_W-1:0] cur_size
);
  localparam int PIX_W  = $clog2(MAX_DIM * MAX_DIM + 1);
  localparam int TRAN_IW = $clog2(TRAN_WORDS);

  cur_st_e st;

  logic [COORD_W-1:0] scr_x, scr_y;
  logic [SZ_W-1:0]    vis_w, vis_h;
  logic [SRC_AW-1:0]  src_start;
  logic [SZ_W:0]      stride;
  logic [CUR_AW-1:0]  seq_addr;

  logic               reload_q, tran_ok, pend, rd_q;
  logic [TRAN_IW-1:0] tran_idx;
  logic [PIX_W-1:0]   wr_cnt, total;
  logic [2*COORD_W-1:0] pend_pos, pend_sz, last_sz, new_sz;

  logic legal, accept, vis_zero, size_chg, need_load, tran_last, walk_go, seq_restart;

  always_comb begin
    legal     = (cur_w <= SZ_W'(MAX_DIM)) && (cur_h <= SZ_W'(MAX_DIM)) &&
                !((cur_w > SZ_W'(MAX_BOTH)) && (cur_h > SZ_W'(MAX_BOTH)));
    accept    = start && legal && (st == S_IDLE);
    vis_zero  = (vis_w == '0) || (vis_h == '0);
    new_sz    = {COORD_W'(vis_h), COORD_W'(vis_w)};
    size_chg  = (new_sz != last_sz);
    need_load = reload_q || size_chg || !tran_ok;
    total     = PIX_W'(vis_w) * PIX_W'(vis_h);
    tran_last = (tran_idx == TRAN_IW'(TRAN_WORDS - 1));
    walk_go   = ((st == S_CALC) && !vis_zero && tran_ok && need_load) ||
                ((st == S_TRAN) && tran_last);
    seq_restart = (st == S_CALC);
    busy      = (st != S_IDLE);
  end

  cursor_geom #(.COORD_W(COORD_W), .SZ_W(SZ_W), .SRC_AW(SRC_AW)) u_geom (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .w        (cur_w),
    .h        (cur_h),
    .x        (cur_x),
    .y        (cur_y),
    .hact     (act_w),
    .vact     (act_h),
    .ilace    (interlace),
    .scr_x    (scr_x),
    .scr_y    (scr_y),
    .vis_w    (vis_w),
    .vis_h    (vis_h),
    .src_start(src_start),
    .stride   (stride)
  );

  cursor_src_walker #(.SZ_W(SZ_W), .SRC_AW(SRC_AW)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .go       (walk_go),
    .base     (src_start),
    .stride   (stride),
    .vis_w    (vis_w),
    .vis_h    (vis_h),
    .src_rd_en(src_rd_en),
    .src_addr (src_addr)
  );

  cursor_sram_seq #(.BANK1(BANK1_BASE), .BANK2(BANK2_BASE)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .restart(seq_restart),
    .step   (rd_q),
    .addr   (seq_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      reload_q   <= 1'b0;
      tran_ok    <= 1'b0;
      tran_idx   <= '0;
      pend       <= 1'b0;
      pend_pos   <= '0;
      pend_sz    <= '0;
      last_sz    <= '0;
      wr_cnt     <= '0;
      rd_q       <= 1'b0;
      sram_we    <= 1'b0;
      sram_addr  <= '0;
      sram_wdata <= '0;
      cur_en     <= 1'b0;
      cur_pos    <= '0;
      cur_size   <= '0;
    end else begin
      sram_we <= 1'b0;
      rd_q    <= src_rd_en;

      if (frame_done && pend) begin
        cur_pos  <= pend_pos;
        cur_size <= pend_sz;
        cur_en   <= 1'b1;
        pend     <= 1'b0;
      end

      if (rd_q) begin
        sram_we    <= 1'b1;
        sram_addr  <= seq_addr;
        sram_wdata <= swap_rb(src_data);
        wr_cnt     <= wr_cnt + 1'b1;
      end

      case (st)
        S_IDLE: begin
          if (accept) begin
            reload_q <= reload;
            st       <= S_CALC;
          end
        end
        S_CALC: begin
          pend   <= 1'b0;
          wr_cnt <= '0;
          if (vis_zero) begin
            cur_en <= 1'b0;
            st     <= S_IDLE;
          end else begin
            if (size_chg) cur_en <= 1'b0;
            if (!tran_ok) begin
              tran_idx <= '0;
              st       <= S_TRAN;
            end else if (need_load) begin
              st <= S_LOAD;
            end else begin
              st <= S_FIN;
            end
          end
        end
        S_TRAN: begin
          sram_we    <= 1'b1;
          sram_addr  <= TRAN_BASE + CUR_AW'(tran_idx);
          sram_wdata <= TRAN_FILL;
          tran_idx   <= tran_idx + 1'b1;
          if (tran_last) begin
            tran_ok <= 1'b1;
            wr_cnt  <= '0;
            st      <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (rd_q && (wr_cnt == total - 1'b1)) st <= S_FIN;
        end
        S_FIN: begin
          pend_pos <= {scr_y, scr_x};
          pend_sz  <= new_sz;
          last_sz  <= new_sz;
          pend     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase

      if (sram_sleep) tran_ok <= 1'b0;
    end
  end

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int          MAX_DIM   = 64,
  parameter int          MAX_BOTH  = 32,
  parameter int          COORD_W   = 16,
  parameter logic [15:0] TRAN_BASE = 16'h0E00,
  parameter logic [31:0] TRAN_FILL = 32'h5555_5555
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   frame_done,
  input logic                   src_rd_en,
  input logic                   sram_we,
  input logic [15:0]            sram_addr,
  input logic [31:0]            sram_wdata,
  input logic                   busy,
  input logic                   cur_en,
  input logic [2*COORD_W-1:0]   cur_size
);
  logic [COORD_W-1:0] sz_w, sz_h;
  assign sz_w = cur_size[COORD_W-1:0];
  assign sz_h = cur_size[2*COORD_W-1:COORD_W];

  // R1
  size_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cur_en |-> (sz_w <= COORD_W'(MAX_DIM) && sz_h <= COORD_W'(MAX_DIM) &&
                !(sz_w > COORD_W'(MAX_BOTH) && sz_h > COORD_W'(MAX_BOTH))));

  // R9
  en_commit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cur_en) |-> $past(frame_done));

  // R9
  size_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_done) |-> $stable(cur_size));

  // R8
  tran_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (sram_we && sram_addr >= TRAN_BASE && sram_addr < TRAN_BASE + 16'd256)
      |-> (sram_wdata == TRAN_FILL));

  // R7
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> busy);

  // R11
  read_busy_chk: assert property (@(posedge clk) disable iff (rst)
    src_rd_en |-> busy);

endmodule

bind cursor_overlay_loader cursor_overlay_chk #(
  .MAX_DIM  (MAX_DIM),
  .MAX_BOTH (MAX_BOTH),
  .COORD_W  (COORD_W),
  .TRAN_BASE(TRAN_BASE),
  .TRAN_FILL(TRAN_FILL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_done(frame_done),
  .src_rd_en (src_rd_en),
  .sram_we   (sram_we),
  .sram_addr (sram_addr),
  .sram_wdata(sram_wdata),
  .busy      (busy),
  .cur_en    (cur_en),
  .cur_size  (cur_size)
);

// File: tb/tb_cursor_overlay_loader.sv
module tb_cursor_overlay_loader;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic               start = 0, reload = 0, interlace = 0, sram_sleep = 0, frame_done = 0;
  logic [6:0]         cur_w = 0, cur_h = 0;
  logic signed [15:0] cur_x = 0, cur_y = 0;
  logic [15:0]        act_w = 16'd640, act_h = 16'd480;
  logic               src_rd_en;
  logic [12:0]        src_addr;
  logic [31:0]        src_data = 0;
  logic               sram_we, busy, cur_en;
  logic [15:0]        sram_addr;
  logic [31:0]        sram_wdata, cur_pos, cur_size;

  cursor_overlay_loader dut (
    .clk(clk), .rst(rst), .start(start), .reload(reload),
    .cur_w(cur_w), .cur_h(cur_h), .cur_x(cur_x), .cur_y(cur_y),
    .act_w(act_w), .act_h(act_h), .interlace(interlace),
    .sram_sleep(sram_sleep), .frame_done(frame_done),
    .src_rd_en(src_rd_en), .src_addr(src_addr), .src_data(src_data),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .busy(busy), .cur_en(cur_en), .cur_pos(cur_pos), .cur_size(cur_size)
  );

  int n_tests = 0, n_fail = 0;

  function automatic logic [31:0] img(input int a);
    return 32'h8040_2010 + a * 32'h0103_0507;
  endfunction

  function automatic logic [31:0] swp(input logic [31:0] p);
    return {p[31:24], p[7:0], p[15:8], p[23:16]};
  endfunction

  function automatic int nxt(input int a);
    int n = a + 1;
    if ((n & 255) == 0) n = n + 32'h0F00;
    if ((n & 32'h30FF) == 0) n = 32'h0D00;
    return n;
  endfunction

  // source image memory, one cycle of latency
  always @(posedge clk) src_data <= img(int'(src_addr));

  logic [15:0] log_a [0:2399];
  logic [31:0] log_d [0:2399];
  int log_n = 0;
  int busy_seen = 0;

  always @(negedge clk) begin
    if (sram_we && log_n < 2400) begin
      log_a[log_n] = sram_addr;
      log_d[log_n] = sram_wdata;
      log_n++;
    end
    if (busy) busy_seen++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int e_px, e_py, e_vw, e_vh;

  task automatic clip(input int pos, input int size, input int act,
                      output int scr, output int off, output int vis);
    if (pos < 0) begin
      scr = 0; off = -pos; vis = (off >= size) ? 0 : size - off;
    end else if (pos + size > act) begin
      scr = pos; off = 0; vis = (act > pos) ? act - pos : 0;
    end else begin
      scr = pos; off = 0; vis = size;
    end
  endtask

  task automatic request(input int w, input int h, input int x, input int y,
                         input bit rl, input bit il);
    log_n = 0;
    busy_seen = 0;
    @(negedge clk);
    cur_w = 7'(w); cur_h = 7'(h); cur_x = 16'(x); cur_y = 16'(y);
    reload = rl; interlace = il; start = 1;
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // run a request and compare every SRAM write against the model
  task automatic scenario(input string tag, input int w, input int h, input int x, input int y,
                          input bit rl, input bit il, input bit exp_tran, input bit exp_img);
    int xs, xo, ys, yo, stride, k, bad;
    logic [15:0] ea;
    logic [31:0] ed;
    clip(x, w, 640, xs, xo, e_vw);
    clip(y, h, 480, ys, yo, e_vh);
    stride = il ? 2 * w : w;
    if (il) begin e_vh = e_vh / 2; ys = ys / 2; end
    e_px = xs; e_py = ys;
    request(w, h, x, y, rl, il);
    k = 0; bad = -1;
    if (exp_tran) begin
      for (int i = 0; i < 256; i++) begin
        if (bad < 0 && (k >= log_n || log_a[k] != 16'(32'h0E00 + i) || log_d[k] != 32'h5555_5555)) bad = k;
        k++;
      end
    end
    chk(bad < 0, {tag, " R8 transparency fill"}, (bad < 0) ? 0 : log_d[bad], 32'h5555_5555);
    bad = -1;
    if (exp_img && e_vw > 0 && e_vh > 0) begin
      ea = 16'h0C00;
      for (int r = 0; r < e_vh; r++) begin
        for (int c = 0; c < e_vw; c++) begin
          ed = swp(img(yo * stride + xo + r * stride + c));
          if (bad < 0 && (k >= log_n || log_a[k] != ea || log_d[k] != ed)) begin
            bad = k;
            chk(0, {tag, " R6 R7 R11 pixel addr/data"},
                (k < log_n) ? {log_a[k], log_d[k][15:0]} : 32'hFFFF_FFFF, {ea, ed[15:0]});
          end
          ea = 16'(nxt(int'(ea)));
          k++;
        end
      end
    end
    if (bad < 0) chk(1, "", 0, 0);
    chk(log_n == k, {tag, " R10 write count"}, log_n, k);
  endtask

  task automatic frame();
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
  endtask

  task automatic check_committed(input string tag);
    chk(cur_en === 1'b1, {tag, " R9 cur_en after frame_done"}, cur_en, 1);
    chk(cur_pos == {16'(e_py), 16'(e_px)}, {tag, " R9 cur_pos"}, cur_pos, {16'(e_py), 16'(e_px)});
    chk(cur_size == {16'(e_vh), 16'(e_vw)}, {tag, " R9 cur_size"}, cur_size, {16'(e_vh), 16'(e_vw)});
  endtask

  task automatic t_reset();
    chk(cur_en == 0 && busy == 0 && sram_we == 0, "reset idle outputs", {busy, sram_we, cur_en}, 0);
    chk(cur_pos == 0 && cur_size == 0, "reset position/size", cur_pos | cur_size, 0);
  endtask

  task automatic t_first();
    // first load after reset: transparency fill first (R8), then image
    scenario("first", 8, 4, 10, 20, 1, 0, 1, 1);
    chk(cur_en == 0, "first R9 not committed before frame_done", cur_en, 0);
    frame();
    check_committed("first");
  endtask

  task automatic t_neg();
    // R2: 16x8 at (-5,-3) -> visible 11x5 from offset (5,3); R10 size change reloads
    scenario("neg R2", 16, 8, -5, -3, 0, 0, 0, 1);
    chk(cur_en == 0, "neg R10 cursor off after size change", cur_en, 0);
    frame();
    check_committed("neg R2");
    chk(cur_size == 32'h0005_000B, "neg R2 visible 11x5", cur_size, 32'h0005_000B);
  endtask

  task automatic t_edge();
    // R3: 32x32 at (630,470) on 640x480 -> visible 10x10
    scenario("edge R3", 32, 32, 630, 470, 0, 0, 0, 1);
    frame();
    check_committed("edge R3");
    chk(cur_size == 32'h000A_000A, "edge R3 visible 10x10", cur_size, 32'h000A_000A);
  endtask

  task automatic t_move();
    // R10: same visible size, no reload -> no writes, old cursor stays on until commit
    scenario("move R10", 10, 10, 5, 5, 0, 0, 0, 0);
    chk(cur_en == 1 && cur_pos == {16'd470, 16'd630}, "move R10 old cursor kept before commit",
        cur_pos, {16'd470, 16'd630});
    frame();
    check_committed("move R10");
  endtask

  task automatic t_illegal();
    // R1: 40x40 exceeds the 32-both limit
    request(40, 40, 0, 0, 1, 0);
    chk(busy_seen == 0 && log_n == 0, "illegal R1 no activity", log_n + busy_seen, 0);
    frame();
    chk(cur_en == 1 && cur_pos == 32'h0005_0005 && cur_size == 32'h000A_000A,
        "illegal R1 outputs unchanged", cur_pos, 32'h0005_0005);
  endtask

  task automatic t_ilace();
    // R4: 16x16 at (0,10) interlaced -> height 8, y 5, stride 32
    scenario("ilace R4", 16, 16, 0, 10, 1, 1, 0, 1);
    frame();
    check_committed("ilace R4");
    chk(cur_pos == 32'h0005_0000 && cur_size == 32'h0008_0010, "ilace R4 halved y and height",
        cur_size, 32'h0008_0010);
  endtask

  task automatic t_zero();
    // R5: fully off the left edge
    scenario("zero R5", 16, 16, -20, 0, 1, 0, 0, 0);
    chk(cur_en == 0, "zero R5 cursor disabled", cur_en, 0);
    frame();
    chk(cur_en == 0, "zero R5 stays disabled after frame_done", cur_en, 0);
  endtask

  task automatic t_big();
    // R7: 2048 pixels cross every block and the bank switch; R1 64x32 accepted
    scenario("big R7", 64, 32, 0, 0, 1, 0, 0, 1);
    chk(log_a[256] == 16'h1C00, "big R7 pixel 256 address", log_a[256], 16'h1C00);
    chk(log_a[1024] == 16'h0D00, "big R7 pixel 1024 address", log_a[1024], 16'h0D00);
    frame();
    check_committed("big R1");
  endtask

  task automatic t_sleep();
    // R8: after contents are lost, same size without reload still fills and reloads
    @(negedge clk); sram_sleep = 1;
    @(negedge clk); sram_sleep = 0;
    scenario("sleep R8", 64, 32, 0, 0, 0, 0, 1, 1);
    chk(cur_en == 1, "sleep R10 same size keeps cursor on", cur_en, 1);
    frame();
    check_committed("sleep R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_first();
    t_neg();
    t_edge();
    t_move();
    t_illegal();
    t_ilace();
    t_zero();
    t_big();
    t_sleep();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule